// File: doc/BRIEF.md
# RGB to Gray Pixel Converter

This block turns a stream of 24-bit colour pixels into gray pixels. Each cycle that `in_valid` is high, the block takes one pixel from `in_rgb`. Red is in bits [23:16], green in [15:8] and blue in [7:0]. It reduces the pixel to one 8-bit intensity and, exactly two cycles later, presents a pixel on `out_rgb` with that intensity in all three colour fields. A 3-bit mode input picks one of five conversion formulas: a fixed-point weighted sum, an integer weighted sum divided by 100, a weighted sum shifted right by 8, a three-way average, and green taken on its own. Every division is exact truncating integer division. It is built as a multiply by a constant reciprocal followed by a shift.

A small flow controller tracks whether any pixel is in flight. It has three named states. `ST_IDLE` means no pixel was accepted in either of the last two cycles. `ST_RUN` means a pixel was accepted in the previous cycle. `ST_DRAIN` means no pixel was accepted in the previous cycle, but one was accepted the cycle before. The transitions are:
- Any state goes to `ST_RUN` when `in_valid` is high.
- `ST_RUN` goes to `ST_DRAIN` when `in_valid` is low.
- `ST_DRAIN` goes to `ST_IDLE` when `in_valid` is low.
- `ST_IDLE` stays in `ST_IDLE` while `in_valid` is low.

The mode input is followed live only in `ST_IDLE`. In the other states the block uses the mode it captured in the last idle cycle, so a burst is never converted with a mix of formulas.

Top module: `gray_convert`

## Requirements
- R1: With mode code 2, gray = (R*76 + G*151 + B*28) >> 8.
- R2: With mode code 1, gray = floor((R*30 + G*59 + B*11) / 100), exact for every 8-bit input.
- R3: Mode code 0 is the fixed-point form of the 0.30/0.59/0.11 weights and gives the same result as mode code 1.
- R4: With mode code 3, gray = floor((R + G + B) / 3), exact for every 8-bit input.
- R5: With mode code 4, gray equals the green field unchanged.
- R6: Mode codes 5, 6 and 7 produce the mode code 2 result.
- R7: Every output pixel carries the gray value in out_rgb[23:16], [15:8] and [7:0] alike, and the value is clamped to at most 255.
- R8: out_valid is high in a cycle exactly when in_valid was high two cycles earlier, in every mode.
- R9: Reset clears out_valid and out_rgb to zero, and out_rgb keeps its last value in every cycle in which out_valid is low.
- R10: A pixel accepted when in_valid was low in both of the two preceding cycles uses the mode_i value of its own cycle. Any other pixel uses the mode_i value of the most recent cycle that met that condition. Changes to mode_i at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Conversion formula select (codes per R1 to R6) |
| in_valid | input | 1 | Input pixel present this cycle |
| in_rgb | input | 24 | Input pixel: R [23:16], G [15:8], B [7:0] |
| out_valid | output | 1 | Output pixel present this cycle |
| out_rgb | output | 24 | Gray pixel, same value in all three fields |

## Verification
Every converted pixel is due on the outputs in the second cycle after the cycle in which it was presented. The flow controller's idle indication is due in the cycle that follows two cycles without input. The bench keeps a two-deep model pipeline that is advanced once per cycle. It compares the ports against that model at the falling edge, so each expected value meets the design's output in exactly the cycle the two registers put it there. The model also tracks the input valid history to decide which mode each pixel is owed. Mode changes placed one and two cycles after a burst ends therefore land on opposite sides of the idle boundary.

// File: rtl/gray_pkg.sv
package gray_pkg;

    // Mode codes seen on mode_i
    localparam logic [2:0] MODE_WFIX   = 3'd0;
    localparam logic [2:0] MODE_INT100 = 3'd1;
    localparam logic [2:0] MODE_SHR8   = 3'd2;
    localparam logic [2:0] MODE_AVG3   = 3'd3;
    localparam logic [2:0] MODE_GREEN  = 3'd4;

    // Arithmetic path taken by a pixel through both stages
    typedef enum logic [1:0] {
        PATH_DIV100 = 2'd0,
        PATH_SHR8   = 2'd1,
        PATH_DIV3   = 2'd2,
        PATH_PASS   = 2'd3
    } gray_path_e;

    // Flow controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } flow_state_e;

    // Weights for the /100 path and the >>8 path
    localparam int W100_R = 30;
    localparam int W100_G = 59;
    localparam int W100_B = 11;
    localparam int W256_R = 76;
    localparam int W256_G = 151;
    localparam int W256_B = 28;

    // Reciprocal constants: floor(x*MUL >> SHR) == floor(x/N) over the
    // ranges reached with 8-bit channels (x <= 25500 for N=100, x <= 765 for N=3)
    localparam int DIV100_MUL = 5243;
    localparam int DIV100_SHR = 19;
    localparam int DIV3_MUL   = 683;
    localparam int DIV3_SHR   = 11;

    function automatic gray_path_e path_of(input logic [2:0] code);
        gray_path_e p;
        case (code)
            MODE_WFIX,
            MODE_INT100: p = PATH_DIV100;
            MODE_AVG3:   p = PATH_DIV3;
            MODE_GREEN:  p = PATH_PASS;
            default:     p = PATH_SHR8;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/gray_flow_ctrl.sv
module gray_flow_ctrl
    import gray_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [2:0] mode_i,
    output gray_path_e path_o,
    output logic       idle_o
);

    flow_state_e state_q;
    flow_state_e state_d;
    logic [2:0]  mode_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_RUN : ST_IDLE;
            ST_RUN:   state_d = in_valid ? ST_RUN : ST_DRAIN;
            ST_DRAIN: state_d = in_valid ? ST_RUN : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Mode capture: follows mode_i only while nothing is in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SHR8;
        end else if (state_q == ST_IDLE) begin
            mode_q <= mode_i;
        end
    end

    // Outputs
    always_comb begin
        idle_o = (state_q == ST_IDLE);
        path_o = path_of(idle_o ? mode_i : mode_q);
    end

endmodule

// File: rtl/gray_weight_sum.sv
module gray_weight_sum
    import gray_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int SUM_W = 2 * CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3*CH_W-1:0] in_rgb,
    input  gray_path_e        path_i,
    output logic              s1_valid,
    output logic [SUM_W-1:0]  s1_sum,
    output gray_path_e        s1_path
);

    localparam int NCH = 3;

    // ch[2] = red, ch[1] = green, ch[0] = blue
    logic [SUM_W-1:0] ch [NCH];

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_unpack
            assign ch[gi] = SUM_W'(in_rgb[gi*CH_W +: CH_W]);
        end
    endgenerate

    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        unique case (path_i)
            PATH_DIV100: sum_d = ch[2] * SUM_W'(W100_R)
                               + ch[1] * SUM_W'(W100_G)
                               + ch[0] * SUM_W'(W100_B);
            PATH_SHR8:   sum_d = ch[2] * SUM_W'(W256_R)
                               + ch[1] * SUM_W'(W256_G)
                               + ch[0] * SUM_W'(W256_B);
            PATH_DIV3:   sum_d = ch[2] + ch[1] + ch[0];
            PATH_PASS:   sum_d = ch[1];
            default:     sum_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
            s1_path  <= PATH_SHR8;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sum  <= sum_d;
                s1_path <= path_i;
            end
        end
    end

endmodule

// File: rtl/gray_scale_div.sv
module gray_scale_div
    import gray_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int SUM_W = 2 * CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [SUM_W-1:0]  s1_sum,
    input  gray_path_e        s1_path,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_rgb
);

    localparam int NCH    = 3;
    localparam int PROD_W = SUM_W + 14;
    localparam logic [SUM_W-1:0] CH_MAX = SUM_W'((1 << CH_W) - 1);

    logic [PROD_W-1:0] prod100;
    logic [PROD_W-1:0] prod3;
    logic [SUM_W-1:0]  quot;
    logic [CH_W-1:0]   gray;

    always_comb begin
        prod100 = PROD_W'(s1_sum) * PROD_W'(DIV100_MUL);
        prod3   = PROD_W'(s1_sum) * PROD_W'(DIV3_MUL);
        quot    = '0;
        unique case (s1_path)
            PATH_DIV100: quot = SUM_W'(prod100 >> DIV100_SHR);
            PATH_SHR8:   quot = s1_sum >> 8;
            PATH_DIV3:   quot = SUM_W'(prod3 >> DIV3_SHR);
            PATH_PASS:   quot = s1_sum;
            default:     quot = '0;
        endcase
        gray = (quot > CH_MAX) ? CH_MAX[CH_W-1:0] : quot[CH_W-1:0];
    end

    logic [3*CH_W-1:0] rgb_d;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_fan
            assign rgb_d[gi*CH_W +: CH_W] = gray;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_rgb <= rgb_d;
            end
        end
    end

endmodule

// File: rtl/gray_convert.sv
module gray_convert
    import gray_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              in_valid,
    input  logic [3*CH_W-1:0] in_rgb,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_rgb
);

    localparam int SUM_W = 2 * CH_W + 1;

    gray_path_e       cur_path;
    logic             flow_idle;
    logic             s1_valid;
    logic [SUM_W-1:0] s1_sum;
    gray_path_e       s1_path;

    gray_flow_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_i   (mode_i),
        .path_o   (cur_path),
        .idle_o   (flow_idle)
    );

    gray_weight_sum #(.CH_W(CH_W), .SUM_W(SUM_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_rgb   (in_rgb),
        .path_i   (cur_path),
        .s1_valid (s1_valid),
        .s1_sum   (s1_sum),
        .s1_path  (s1_path)
    );

    gray_scale_div #(.CH_W(CH_W), .SUM_W(SUM_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_sum    (s1_sum),
        .s1_path   (s1_path),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

endmodule

// File: rtl/gray_convert_chk.sv
module gray_convert_chk #(
    parameter int CH_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [3*CH_W-1:0] out_rgb,
    input logic              idle_i
);

    // Clock edges seen since reset release, saturating at 3
    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    // R8: valid comes out exactly two cycles after it went in
    a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7: the three fields of an output pixel agree
    a_r7_fields_equal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_rgb[3*CH_W-1:2*CH_W] == out_rgb[2*CH_W-1:CH_W]) &&
                       (out_rgb[2*CH_W-1:CH_W]   == out_rgb[CH_W-1:0])));

    // R9: data holds while no pixel is presented
    a_r9_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen >= 2'd1) && !out_valid) |-> $stable(out_rgb));

    // R10: the controller is idle exactly after two cycles without input
    a_r10_idle_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (idle_i == !($past(in_valid, 1) || $past(in_valid, 2))));

endmodule

bind gray_convert gray_convert_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .idle_i    (flow_idle)
);

// File: tb/gray_convert_tb.sv
module gray_convert_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic        in_valid = 1'b0;
    logic [23:0] in_rgb = 24'd0;
    logic        out_valid;
    logic [23:0] out_rgb;

    always #2 clk = ~clk; // 250 MHz

    gray_convert u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .in_valid  (in_valid),
        .in_rgb    (in_rgb),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );

    int checks = 0;
    int failures = 0;

    // Reference model state
    bit          h1 = 0, h2 = 0;
    int          last_mode = 0;
    bit          m1_v = 0, m_out_v = 0;
    logic [23:0] m1_d = '0, m_out_d = '0;
    string       m1_tag = "", m_out_tag = "";
    string       phase = "";

    function automatic int ref_gray(int m, int r, int g, int b);
        case (m)
            0, 1:    return (r * 30 + g * 59 + b * 11) / 100;
            3:       return (r + g + b) / 3;
            4:       return g;
            default: return (r * 76 + g * 151 + b * 28) / 256;
        endcase
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0:       return "R3";
            1:       return "R2";
            2:       return "R1";
            3:       return "R4";
            4:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: compare outputs with the model, then drive the next input
    task automatic step(bit v, int m, logic [23:0] rgb);
        int act_m;
        int gv;
        bit idle_now;
        @(negedge clk);
        check("R8 out_valid", 32'(out_valid), 32'(m_out_v));
        if (m_out_v)
            check({m_out_tag, "/R7 pixel"}, 32'(out_rgb), 32'(m_out_d));
        else
            check("R9 hold while invalid", 32'(out_rgb), 32'(m_out_d));
        m_out_v = m1_v;
        if (m1_v) begin
            m_out_d   = m1_d;
            m_out_tag = m1_tag;
        end
        idle_now = !h1 && !h2;
        if (idle_now) last_mode = m;
        act_m = idle_now ? m : last_mode;
        m1_v = v;
        if (v) begin
            gv = ref_gray(act_m, int'(rgb[23:16]), int'(rgb[15:8]), int'(rgb[7:0]));
            if (gv > 255) gv = 255;
            m1_d   = {3{gv[7:0]}};
            m1_tag = {mode_tag(act_m), phase};
        end
        h2 = h1;
        h1 = v;
        mode_i   = 3'(m);
        in_valid = v;
        in_rgb   = rgb;
    endtask

    task automatic burst(int m, int n, bit corners);
        logic [23:0] px;
        for (int i = 0; i < n; i++) begin
            if (corners) begin
                case (i % 8)
                    0: px = 24'h000000;
                    1: px = 24'hFFFFFF;
                    2: px = 24'hFF0000;
                    3: px = 24'h00FF00;
                    4: px = 24'h0000FF;
                    5: px = 24'hFFFF00;
                    6: px = 24'h01FE63;
                    default: px = 24'h7F8081;
                endcase
            end else begin
                px = 24'($urandom);
            end
            step(1'b1, m, px);
        end
    endtask

    task automatic gap(int m, int n);
        for (int i = 0; i < n; i++) step(1'b0, m, 24'h0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset out_valid", 32'(out_valid), 32'd0);
        check("R9 reset out_rgb", 32'(out_rgb), 32'd0);
        rst_n = 1'b1;

        // Corner pixels, then random pixels, in every mode code (R1..R6)
        for (int m = 0; m < 8; m++) begin
            burst(m, 8, 1'b1);
            gap(m, 3);
            burst(m, 400, 1'b0);
            gap(m, 3);
        end

        // Sparse input with single-cycle gaps, latency check (R8)
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 3, 24'($urandom));
            gap(3, 1);
        end
        gap(3, 3);

        // R10: mode change during a burst is ignored
        phase = "/R10";
        burst(3, 3, 1'b0);
        step(1'b1, 4, 24'h30C050);
        step(1'b1, 2, 24'hA01020);
        // one-cycle gap keeps the old mode
        step(1'b0, 4, 24'h0);
        step(1'b1, 4, 24'h90F011);
        // two-cycle gap reaches idle, new mode applies
        gap(4, 2);
        step(1'b1, 4, 24'h90F011);
        step(1'b1, 1, 24'h12EE34);
        gap(1, 3);
        phase = "";

        // Exhaustive-ish sweep of the /100 and /3 paths (R2, R4)
        for (int i = 0; i < 3000; i++) step(1'b1, 1, 24'($urandom));
        gap(1, 3);
        for (int i = 0; i < 3000; i++) step(1'b1, 3, 24'($urandom));
        gap(3, 4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule